// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block produces the system reset for a microcontroller. Three events start a reset: power arriving, the supply-good flag from an external comparator dropping, and the watchdog running out because no service pulse arrived in time. All three share one stretch timer, so after any of them the reset stays asserted for a fixed number of millisecond ticks before it releases. The reset is driven on two pins of opposite polarity.

The watchdog is serviced by pulses on the chip-select line of the serial bus. A falling edge of the active-low select, after a two-flop synchronizer, restarts the count. A 2-bit select field picks one of three periods or switches the watchdog off. All periods are counted in cycles of a one-clock tick enable, and parameters set every count, so a simulation can use short values.

Top module: `supv_reset`

## Requirements
- R1: While `supplyOk` has been low since start, `rstN` is 0 and `rst` is 1. After `supplyOk` rises, reset stays asserted for `HOLD_TICKS` ticks (plus at most one tick of synchronizer latency) and then releases.
- R2: When `supplyOk` falls, `rstN` goes low at once without waiting for a clock edge. Reset stays asserted while the flag is low, and after the flag returns it is held for the stretch period again.
- R3: `rst` is always the complement of `rstN` once a clock edge has passed with `supplyOk` high.
- R4: With `wdSel` = 2'b11, the default code, reset is asserted after `WD_TICKS_SHORT` ticks without a service pulse.
- R5: With `wdSel` = 2'b10 the watchdog period is `WD_TICKS_MID` ticks. With `wdSel` = 2'b01 it is `WD_TICKS_LONG` ticks.
- R6: With `wdSel` = 2'b00 the watchdog never asserts reset, however long the select line stays idle.
- R7: A falling edge on `csN` restarts the watchdog count, two clocks after the edge. Pulses that come more often than the period keep reset released.
- R8: The watchdog count is held at zero while reset is asserted. The first period after a release is measured from the release.
- R9: Any change of `wdSel` while running restarts the watchdog count, which then uses the new period.
- R10: A reset caused by the watchdog lasts exactly `HOLD_TICKS` ticks.
- R11: Reset asserted by the watchdog, and any reset release, change only on a clock edge where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| tick | input | 1 | One-cycle enable, nominally once per millisecond |
| supplyOk | input | 1 | Supply-good flag from the external comparator, asynchronous |
| csN | input | 1 | Active-low chip select; its falling edge services the watchdog |
| wdSel | input | 2 | Watchdog period code: 11 short, 10 mid, 01 long, 00 off |
| rstN | output | 1 | Active-low system reset |
| rst | output | 1 | Active-high system reset |

## Verification
The assertions check four things on every cycle: that the two outputs stay complementary, that a low supply flag never coexists with a released reset, that releases and watchdog-caused resets fall on tick cycles and never occur with the watchdog off, and that no low phase outlasts the stretch bound. The exact period lengths for each select code can only be shown by the bench's scenarios, which count ticks between events. The same holds for restarting by a select pulse or a code change, and for a watchdog period being measured from release rather than from the trigger.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } rstState_e;

  // Strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic holdClr;
    logic holdCount;
    logic wdClr;
    logic wdCount;
  } ctrlStrobes_t;

endpackage

// File: rtl/supv_reset_count.sv
module supv_reset_count
  import supv_reset_pkg::*;
#(
  parameter int HOLD_TICKS     = 200,
  parameter int WD_TICKS_SHORT = 200,
  parameter int WD_TICKS_MID   = 600,
  parameter int WD_TICKS_LONG  = 1400
) (
  input  logic         clk,
  input  logic         supplyOk,
  input  logic         tick,
  input  logic         csN,
  input  logic [1:0]   wdSel,
  input  ctrlStrobes_t strobes,
  output logic         holdDone,
  output logic         wdDone
);

  localparam int MAX_A  = (HOLD_TICKS > WD_TICKS_SHORT) ? HOLD_TICKS : WD_TICKS_SHORT;
  localparam int MAX_B  = (WD_TICKS_MID > WD_TICKS_LONG) ? WD_TICKS_MID : WD_TICKS_LONG;
  localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(WD_TICKS_SHORT - 1);
  localparam logic [CNT_W-1:0] MID_LAST   = CNT_W'(WD_TICKS_MID - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(WD_TICKS_LONG - 1);

  logic [1:0]       csSync;
  logic             csPrev;
  logic [1:0]       selPrev;
  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] wdCnt;
  logic [CNT_W-1:0] wdLast;
  logic             wdOn;
  logic             kick;
  logic             selChanged;

  // Select line synchronizer and falling-edge detect
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      csSync  <= 2'b11;
      csPrev  <= 1'b1;
      selPrev <= 2'b11;
    end else begin
      csSync  <= {csSync[0], csN};
      csPrev  <= csSync[1];
      selPrev <= wdSel;
    end
  end

  assign kick       = csPrev & ~csSync[1];
  assign selChanged = (selPrev != wdSel);

  always_comb begin
    wdOn   = 1'b1;
    wdLast = SHORT_LAST;
    case (wdSel)
      2'b11:   wdLast = SHORT_LAST;
      2'b10:   wdLast = MID_LAST;
      2'b01:   wdLast = LONG_LAST;
      default: wdOn   = 1'b0;
    endcase
  end

  // Stretch counter
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      holdCnt <= '0;
    end else if (strobes.holdClr) begin
      holdCnt <= '0;
    end else if (strobes.holdCount && tick) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = strobes.holdCount && tick && (holdCnt == HOLD_LAST);

  // Watchdog counter
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      wdCnt <= '0;
    end else if (strobes.wdClr || kick || selChanged) begin
      wdCnt <= '0;
    end else if (strobes.wdCount && wdOn && tick) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  assign wdDone = strobes.wdCount && wdOn && tick && !kick && !selChanged
                  && (wdCnt == wdLast);

endmodule

// File: rtl/supv_reset_fsm.sv
module supv_reset_fsm
  import supv_reset_pkg::*;
(
  input  logic         clk,
  input  logic         supplyOk,
  input  logic         holdDone,
  input  logic         wdDone,
  output ctrlStrobes_t strobes,
  output logic         rstN,
  output logic         rst
);

  rstState_e  state;
  rstState_e  stateNext;
  logic [1:0] okSync;
  logic       rstNReg;
  logic       rstReg;

  always_comb begin
    stateNext = state;
    case (state)
      ST_OFF:  if (okSync[1]) stateNext = ST_HOLD;
      ST_HOLD: if (holdDone)  stateNext = ST_RUN;
      ST_RUN:  if (wdDone)    stateNext = ST_HOLD;
      default: stateNext = ST_OFF;
    endcase
  end

  // Asynchronous assert on supply loss, synchronized release
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      okSync  <= 2'b00;
      state   <= ST_OFF;
      rstNReg <= 1'b0;
      rstReg  <= 1'b1;
    end else begin
      okSync  <= {okSync[0], 1'b1};
      state   <= stateNext;
      rstNReg <= (stateNext == ST_RUN);
      rstReg  <= (stateNext != ST_RUN);
    end
  end

  always_comb begin
    strobes.holdClr   = (state != ST_HOLD);
    strobes.holdCount = (state == ST_HOLD);
    strobes.wdClr     = (state != ST_RUN);
    strobes.wdCount   = (state == ST_RUN);
  end

  assign rstN = rstNReg;
  assign rst  = rstReg;

endmodule

// File: rtl/supv_reset.sv
module supv_reset
  import supv_reset_pkg::*;
#(
  parameter int HOLD_TICKS     = 200,
  parameter int WD_TICKS_SHORT = 200,
  parameter int WD_TICKS_MID   = 600,
  parameter int WD_TICKS_LONG  = 1400
) (
  input  logic       clk,
  input  logic       tick,
  input  logic       supplyOk,
  input  logic       csN,
  input  logic [1:0] wdSel,
  output logic       rstN,
  output logic       rst
);

  ctrlStrobes_t strobes;
  logic         holdDone;
  logic         wdDone;

  supv_reset_fsm u_fsm (
    .clk      (clk),
    .supplyOk (supplyOk),
    .holdDone (holdDone),
    .wdDone   (wdDone),
    .strobes  (strobes),
    .rstN     (rstN),
    .rst      (rst)
  );

  supv_reset_count #(
    .HOLD_TICKS     (HOLD_TICKS),
    .WD_TICKS_SHORT (WD_TICKS_SHORT),
    .WD_TICKS_MID   (WD_TICKS_MID),
    .WD_TICKS_LONG  (WD_TICKS_LONG)
  ) u_count (
    .clk      (clk),
    .supplyOk (supplyOk),
    .tick     (tick),
    .csN      (csN),
    .wdSel    (wdSel),
    .strobes  (strobes),
    .holdDone (holdDone),
    .wdDone   (wdDone)
  );

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int HOLD_TICKS = 200
) (
  input logic       clk,
  input logic       tick,
  input logic       supplyOk,
  input logic [1:0] wdSel,
  input logic       rstN,
  input logic       rst
);

  localparam int LOW_W = $clog2(HOLD_TICKS + 3);

  logic [LOW_W-1:0] lowTicks;

  // Ticks spent in one low phase while the supply is good
  always_ff @(posedge clk) begin
    if (!supplyOk || rstN) lowTicks <= '0;
    else if (tick)         lowTicks <= lowTicks + 1'b1;
  end

  assert_polarity_R3: assert property (@(posedge clk) disable iff (!supplyOk)
    rst == !rstN);

  assert_supply_low_R2: assert property (@(posedge clk)
    !supplyOk |-> rstN !== 1'b1);

  assert_release_on_tick_R11: assert property (@(posedge clk) disable iff (!supplyOk)
    $rose(rstN) |-> $past(tick));

  assert_expiry_on_tick_R11: assert property (@(posedge clk) disable iff (!supplyOk)
    $fell(rstN) |-> $past(tick));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!supplyOk)
    $fell(rstN) |-> $past(wdSel) != 2'b00);

  assert_stretch_bound_R1: assert property (@(posedge clk) disable iff (!supplyOk)
    lowTicks <= LOW_W'(HOLD_TICKS + 1));

endmodule

bind supv_reset supv_reset_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk      (clk),
  .tick     (tick),
  .supplyOk (supplyOk),
  .wdSel    (wdSel),
  .rstN     (rstN),
  .rst      (rst)
);

// File: tb/supv_reset_tb.sv
module supv_reset_tb;

  localparam int HOLD  = 6;
  localparam int WSHRT = 10;
  localparam int WMID  = 16;
  localparam int WLONG = 24;
  localparam int DIV   = 4;

  logic       clk = 1'b0;
  logic       tick = 1'b0;
  logic       supplyOk = 1'b0;
  logic       csN = 1'b1;
  logic [1:0] wdSel = 2'b11;
  logic       rstN;
  logic       rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supv_reset #(
    .HOLD_TICKS     (HOLD),
    .WD_TICKS_SHORT (WSHRT),
    .WD_TICKS_MID   (WMID),
    .WD_TICKS_LONG  (WLONG)
  ) u_dut (
    .clk      (clk),
    .tick     (tick),
    .supplyOk (supplyOk),
    .csN      (csN),
    .wdSel    (wdSel),
    .rstN     (rstN),
    .rst      (rst)
  );

  // Tick enable: one cycle out of DIV, changed just after the rising edge
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph   = (ph + 1) % DIV;
      tick = (ph == 0);
    end
  end

  task automatic checkRange(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // Ticks seen while reset is low, until it releases
  task automatic countLow(output int n);
    n = 0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (rstN) break;
      if (tick) n++;
    end
  endtask

  // Ticks seen while reset is released, until it asserts
  task automatic countHigh(output int n);
    n = 0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (!rstN) break;
      if (tick) n++;
    end
  endtask

  task automatic waitTicks(int k);
    int n = 0;
    while (n < k) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  task automatic kick();
    @(posedge clk);
    #1 csN = 1'b0;
    @(posedge clk);
    #1 csN = 1'b1;
  endtask

  task automatic testResetState();
    repeat (5) @(negedge clk);
    checkRange("R1", "rstN while supply low", int'(rstN), 0, 0);
    checkRange("R3", "rst while supply low", int'(rst), 1, 1);
  endtask

  task automatic testPowerUp();
    int n;
    @(posedge clk);
    #1 supplyOk = 1'b1;
    countLow(n);
    checkRange("R1", "power-up stretch ticks", n, HOLD, HOLD + 1);
    checkRange("R3", "rst after release", int'(rst), 0, 0);
  endtask

  task automatic testDefaultExpiry();
    int n;
    countHigh(n);
    checkRange("R8", "first default period from release", n, WSHRT, WSHRT);
    checkRange("R4", "default period ticks", n, WSHRT, WSHRT + 1);
    checkRange("R3", "rst on watchdog reset", int'(rst), 1, 1);
    countLow(n);
    checkRange("R10", "watchdog reset length", n, HOLD, HOLD);
  endtask

  task automatic testKicks();
    int n;
    for (int i = 0; i < 8; i++) begin
      kick();
      waitTicks(WSHRT - 4);
      checkRange("R7", "serviced reset stays released", int'(rstN), 1, 1);
    end
    kick();
    countHigh(n);
    checkRange("R7", "period after last service", n, WSHRT - 1, WSHRT + 1);
    countLow(n);
  endtask

  task automatic testPeriod(logic [1:0] code, int lim, string req);
    int n;
    @(negedge clk);
    wdSel = code;
    countHigh(n);
    checkRange(req, "period for code", n, lim - 1, lim + 1);
    countLow(n);
  endtask

  task automatic testDisabled();
    @(negedge clk);
    wdSel = 2'b00;
    waitTicks(4 * WLONG);
    checkRange("R6", "disabled watchdog no reset", int'(rstN), 1, 1);
  endtask

  task automatic testSelChange();
    int n;
    @(negedge clk);
    wdSel = 2'b11;
    kick();
    waitTicks(WSHRT - 3);
    checkRange("R9", "released before code change", int'(rstN), 1, 1);
    @(negedge clk);
    wdSel = 2'b10;
    countHigh(n);
    checkRange("R9", "period after code change", n, WMID - 1, WMID + 1);
    countLow(n);
  endtask

  task automatic testSupplyDrop();
    int n;
    @(negedge clk);
    wdSel = 2'b00;
    waitTicks(3);
    @(posedge clk);
    #1 supplyOk = 1'b0;
    #1;
    checkRange("R2", "rstN right after supply drop", int'(rstN), 0, 0);
    checkRange("R2", "rst right after supply drop", int'(rst), 1, 1);
    waitTicks(2 * HOLD);
    checkRange("R2", "reset held while supply low", int'(rstN), 0, 0);
    @(posedge clk);
    #1 supplyOk = 1'b1;
    countLow(n);
    checkRange("R2", "stretch after supply returns", n, HOLD, HOLD + 1);
  endtask

  initial begin
    testResetState();
    testPowerUp();
    testDefaultExpiry();
    testKicks();
    testPeriod(2'b10, WMID, "R5");
    testPeriod(2'b01, WLONG, "R5");
    testDisabled();
    testSelChange();
    testSupplyDrop();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule